// File: doc/BRIEF.md
# Three-Wire Saturating Wiper Position Controller

This block is the digital control core of a 32-position digitally controlled potentiometer. A host drives three slow control lines: an active-low select (`csN`), a direction level (`upNotDown`) and a step line (`stepIn`). The block samples all three on the system clock through two-stage synchronizers. While the block is selected, each high-to-low transition of the step line moves a wiper position counter by one tap. The counter stops at both ends and never wraps. The position is decoded into a one-hot tap-select vector, which drives the transfer gates of the analog array.

The block also holds a modeled non-volatile register. When the host releases select while the step line is high, the current position is captured and a store begins. The store is modeled by a busy period of `STORE_CYCLES` clocks, and the register takes the captured value when that period ends. When the host releases select while the step line is low, the move is kept in the counter but nothing is saved.

Two resets are provided. The power-on reset (`porN`) loads the register with `NV_INIT`. The soft power-cycle reset (`pwrN`) keeps the register and reloads the counter from it. Either reset therefore recalls the last saved position. A standby flag reports that the block is neither selected nor storing.

Top module: `digipot_wiper`

## Requirements
- R1: `tapSel` is always one-hot. Bit k is set exactly when the wiper position is k (0..31).
- R2: The position changes only on a high-to-low transition of the synchronized `stepIn` while the block is selected. A rising `stepIn`, or any `stepIn` activity in standby, leaves the position unchanged.
- R3: A step moves the position up by one when `upNotDown` is 1 and down by one when it is 0. The direction may be reversed between steps within one selection.
- R4: An up step at position 31 and a down step at position 0 leave the position unchanged. The position never wraps.
- R5: When `csN` rises while `stepIn` is high, the position is captured and `storeBusy` is high for `STORE_CYCLES` clocks. The stored value becomes the non-volatile value when the busy period ends.
- R6: When `csN` rises while `stepIn` is low, no store starts (`storeBusy` stays 0) and the position is kept.
- R7: While `porN` is 0, the position becomes `NV_INIT`. While only `pwrN` is 0, the position becomes the last stored non-volatile value, and that value survives the soft reset.
- R8: A falling `csN` seen while `storeBusy` is high does not select the block. Steps during that selection are ignored, and the block needs a fresh `csN` fall after the busy period ends.
- R9: Each input acts through a two-flop synchronizer. A change on an input pin, sampled at one clock edge, shows on `tapSel` or `storeBusy` after the third clock edge.
- R10: `standby` is 1 exactly when the block is not selected and no store is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Synchronous active-low power-on reset; initializes the non-volatile register |
| pwrN | input | 1 | Synchronous active-low soft power-cycle reset; keeps the non-volatile register |
| csN | input | 1 | Active-low select |
| stepIn | input | 1 | Step line; a falling edge moves the wiper |
| upNotDown | input | 1 | Step direction: 1 up, 0 down |
| tapSel | output | TAPS | One-hot tap select |
| storeBusy | output | 1 | Store in progress |
| standby | output | 1 | Not selected and not storing |

## Verification
Two situations are hard to reach from the ports. The first is a selection attempt that arrives while a store is still busy and then stays low after the busy period ends. The bench drops `csN` a few clocks after a storing deselect, issues steps across the whole busy window and after it, and expects the position to stay frozen until `csN` is cycled. The second is whether a store really reached the non-volatile register. That register is not a port, so the bench reads it back by pulsing the soft reset and observing the recalled tap. It then pulses the power-on reset to show that only that reset returns `NV_INIT`.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

  // Strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic stepUp;   // move one tap toward the top
    logic stepDn;   // move one tap toward the bottom
    logic capture;  // latch the position for a store
    logic commit;   // write the latched position into the non-volatile register
  } wiperStrobe_t;

endpackage

// File: rtl/digipot_sync.sv
module digipot_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= RST_VAL[b];
        stage2 <= RST_VAL[b];
      end else begin
        stage1 <= din[b];
        stage2 <= stage1;
      end
    end
    assign dout[b] = stage2;
  end

endmodule

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter int STORE_CYCLES = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csS,
  input  logic         incS,
  input  logic         udS,
  output wiperStrobe_t strobe,
  output logic         busy,
  output logic         standby
);

  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  logic             csPrev, incPrev, selected;
  logic [CNT_W-1:0] busyCnt;
  logic             csFall, csRise, incFall;

  always_comb begin
    csFall  = csPrev & ~csS;
    csRise  = ~csPrev & csS;
    incFall = incPrev & ~incS;
    busy    = (busyCnt != '0);
    standby = ~selected & ~busy;

    strobe.stepUp  = selected & ~csS & incFall & udS;
    strobe.stepDn  = selected & ~csS & incFall & ~udS;
    strobe.capture = selected & csRise & incS;
    strobe.commit  = (busyCnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      incPrev  <= 1'b1;
      selected <= 1'b0;
      busyCnt  <= '0;
    end else begin
      csPrev  <= csS;
      incPrev <= incS;

      if (selected && csRise)
        selected <= 1'b0;
      else if (csFall && !busy)
        selected <= 1'b1;

      if (strobe.capture)
        busyCnt <= CNT_W'(STORE_CYCLES);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/digipot_dp.sv
module digipot_dp
  import digipot_pkg::*;
#(
  parameter int TAPS    = 32,
  parameter int NV_INIT = 16
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            rstN,
  input  wiperStrobe_t    strobe,
  output logic [TAPS-1:0] tapSel
);

  localparam int POS_W = $clog2(TAPS);
  localparam logic [POS_W-1:0] TOP_POS  = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] INIT_POS = POS_W'(NV_INIT);

  logic [POS_W-1:0] pos, pending, nvReg;

  // Modeled non-volatile cell: only the power-on reset touches it
  always_ff @(posedge clk) begin
    if (!porN) begin
      nvReg   <= INIT_POS;
      pending <= INIT_POS;
    end else begin
      if (strobe.capture) pending <= pos;
      if (strobe.commit)  nvReg   <= pending;
    end
  end

  // Saturating wiper counter with recall on either reset
  always_ff @(posedge clk) begin
    if (!porN)
      pos <= INIT_POS;
    else if (!rstN)
      pos <= nvReg;
    else if (strobe.stepUp && pos != TOP_POS)
      pos <= pos + 1'b1;
    else if (strobe.stepDn && pos != '0)
      pos <= pos - 1'b1;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (pos == POS_W'(t));
  end

endmodule

// File: rtl/digipot_wiper.sv
module digipot_wiper
  import digipot_pkg::*;
#(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 20,
  parameter int NV_INIT      = 16
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            pwrN,
  input  logic            csN,
  input  logic            stepIn,
  input  logic            upNotDown,
  output logic [TAPS-1:0] tapSel,
  output logic            storeBusy,
  output logic            standby
);

  logic         rstN;
  logic [2:0]   syncOut;
  wiperStrobe_t strobe;

  assign rstN = porN & pwrN;

  // bit 2: select, bit 1: step, bit 0: direction
  digipot_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, stepIn, upNotDown}),
    .dout(syncOut)
  );

  digipot_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csS    (syncOut[2]),
    .incS   (syncOut[1]),
    .udS    (syncOut[0]),
    .strobe (strobe),
    .busy   (storeBusy),
    .standby(standby)
  );

  digipot_dp #(.TAPS(TAPS), .NV_INIT(NV_INIT)) u_dp (
    .clk   (clk),
    .porN  (porN),
    .rstN  (rstN),
    .strobe(strobe),
    .tapSel(tapSel)
  );

endmodule

// File: rtl/digipot_wiper_chk.sv
module digipot_wiper_chk #(
  parameter int TAPS = 32
) (
  input logic            clk,
  input logic            porN,
  input logic            pwrN,
  input logic [TAPS-1:0] tapSel,
  input logic            storeBusy,
  input logic            standby
);

  // R1
  a_r1_onehot_tap: assert property (@(posedge clk) disable iff (!porN || !pwrN)
    $onehot(tapSel));

  // R4: any change is a single step to a neighbour, so 31 -> 0 or 0 -> 31 is impossible
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!porN || !pwrN)
    (tapSel != $past(tapSel)) |->
      ((tapSel == ($past(tapSel) << 1)) || (tapSel == ($past(tapSel) >> 1))));

  // R2: no movement in the cycle after standby
  a_r2_idle_no_move: assert property (@(posedge clk) disable iff (!porN || !pwrN)
    standby |=> $stable(tapSel));

  // R8: no movement while a store is busy
  a_r8_busy_frozen: assert property (@(posedge clk) disable iff (!porN || !pwrN)
    storeBusy |-> $stable(tapSel));

  // R10
  a_r10_busy_not_standby: assert property (@(posedge clk) disable iff (!porN || !pwrN)
    storeBusy |-> !standby);

endmodule

bind digipot_wiper digipot_wiper_chk #(.TAPS(TAPS)) u_chk (
  .clk      (clk),
  .porN     (porN),
  .pwrN     (pwrN),
  .tapSel   (tapSel),
  .storeBusy(storeBusy),
  .standby  (standby)
);

// File: tb/sim_digipot_wiper.sv
module sim_digipot_wiper;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS       = 32;
  localparam int STORE      = 20;
  localparam int NVI        = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic porN = 1'b0, pwrN = 1'b1, csN = 1'b1, stepIn = 1'b1, upNotDown = 1'b0;
  logic [TAPS-1:0] tapSel;
  logic storeBusy, standby;

  digipot_wiper #(.TAPS(TAPS), .STORE_CYCLES(STORE), .NV_INIT(NVI)) u0 (
    .clk(clk), .porN(porN), .pwrN(pwrN), .csN(csN), .stepIn(stepIn),
    .upNotDown(upNotDown), .tapSel(tapSel), .storeBusy(storeBusy), .standby(standby)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int idxOf(input logic [TAPS-1:0] v);
    int r = -1;
    for (int i = 0; i < TAPS; i++) if (v[i]) r = i;
    return r;
  endfunction

  // Behavioural reference model: input history queue of {cs, step, dir}
  int mPos = NVI, mNv = NVI, mPend = NVI, mCnt = 0;
  bit mSel = 1'b0, started = 1'b0;
  logic [2:0] hq[$] = '{3'b110, 3'b110, 3'b110};

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    bit wasBusy;
    started = 1'b1;
    if (!porN) begin mNv = NVI; mPend = NVI; end
    if (!porN || !pwrN) begin
      mPos = mNv; mSel = 1'b0; mCnt = 0;
      hq.push_front(3'b110);
    end else begin
      cur = hq[1];
      prv = hq[2];
      wasBusy = (mCnt != 0);
      if (mCnt == 1) mNv = mPend;
      if (mCnt != 0) mCnt--;
      if (mSel && !prv[2] && cur[2]) begin
        mSel = 1'b0;
        if (cur[1]) begin mPend = mPos; mCnt = STORE; end
      end else if (mSel && prv[1] && !cur[1] && !cur[2]) begin
        if (cur[0] && mPos < TAPS-1) mPos++;
        else if (!cur[0] && mPos > 0) mPos--;
      end else if (!mSel && !wasBusy && prv[2] && !cur[2]) begin
        mSel = 1'b1;
      end
      hq.push_front({csN, stepIn, upNotDown});
    end
    hq = hq[0:2];
  end

  // Every-clock comparison, away from the active edge (R1, R9, R5, R10)
  always @(negedge clk) begin
    if (started && !finished) begin
      check(tapSel == (TAPS'(1) << mPos), "R1/R9 tap select vs model", idxOf(tapSel), mPos);
      check(storeBusy == (mCnt != 0), "R5/R9 busy vs model", storeBusy, mCnt != 0);
      check(standby == (!mSel && mCnt == 0), "R10 standby vs model", standby, !mSel && mCnt == 0);
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit up);
    @(negedge clk) upNotDown = up;
    waitN(3);
    stepIn = 1'b0; waitN(4);
    stepIn = 1'b1; waitN(4);
  endtask

  task automatic setCs(input bit v);
    @(negedge clk) csN = v;
    waitN(4);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitN(5);
    porN = 1'b1;
    waitN(2);
    check(idxOf(tapSel) == NVI, "R7 power-on position", idxOf(tapSel), NVI);
    check(standby == 1'b1, "R10 standby after reset", standby, 1);

    // stepIn activity in standby is ignored
    pulse(1'b1);
    check(idxOf(tapSel) == NVI, "R2 no move in standby", idxOf(tapSel), NVI);

    setCs(1'b0);
    check(standby == 1'b0, "R10 selected not standby", standby, 0);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    check(idxOf(tapSel) == 19, "R3 three up steps", idxOf(tapSel), 19);
    pulse(1'b0);
    check(idxOf(tapSel) == 18, "R3 reversal within selection", idxOf(tapSel), 18);

    // storing deselect
    setCs(1'b1);
    check(storeBusy == 1'b1, "R5 busy after storing deselect", storeBusy, 1);
    // selection attempt while busy
    setCs(1'b0);
    pulse(1'b1); pulse(1'b1);
    check(idxOf(tapSel) == 18, "R8 steps ignored while busy", idxOf(tapSel), 18);
    waitN(30);
    check(storeBusy == 1'b0, "R5 busy ends", storeBusy, 0);
    pulse(1'b1);
    check(idxOf(tapSel) == 18, "R8 no selection without fresh fall", idxOf(tapSel), 18);
    setCs(1'b1);
    check(standby == 1'b1, "R10 standby after store", standby, 1);

    // saturation at the top, then discarding deselect
    setCs(1'b0);
    for (int i = 0; i < 20; i++) pulse(1'b1);
    check(idxOf(tapSel) == 31, "R4 saturate at 31", idxOf(tapSel), 31);
    @(negedge clk) upNotDown = 1'b0;
    waitN(3);
    stepIn = 1'b0; waitN(4);
    check(idxOf(tapSel) == 30, "R6 step before discard", idxOf(tapSel), 30);
    setCs(1'b1);
    check(storeBusy == 1'b0, "R6 no store on low-step deselect", storeBusy, 0);
    stepIn = 1'b1; waitN(4);
    check(idxOf(tapSel) == 30, "R6 position kept", idxOf(tapSel), 30);

    // soft power cycle recalls the stored 18
    @(negedge clk) pwrN = 1'b0;
    waitN(3);
    pwrN = 1'b1;
    waitN(2);
    check(idxOf(tapSel) == 18, "R7 soft reset recalls stored value", idxOf(tapSel), 18);

    // saturation at the bottom, store 0, recall it
    setCs(1'b0);
    for (int i = 0; i < 25; i++) pulse(1'b0);
    check(idxOf(tapSel) == 0, "R4 saturate at 0", idxOf(tapSel), 0);
    setCs(1'b1);
    waitN(30);
    @(negedge clk) pwrN = 1'b0;
    waitN(3);
    pwrN = 1'b1;
    waitN(2);
    check(idxOf(tapSel) == 0, "R5 stored 0 recalled", idxOf(tapSel), 0);
    @(negedge clk) porN = 1'b0;
    waitN(3);
    porN = 1'b1;
    waitN(2);
    check(idxOf(tapSel) == NVI, "R7 power-on reload of initial value", idxOf(tapSel), NVI);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule